// File: doc/BRIEF.md
# Legacy I/O Positive-Decode Claim Unit

This block watches the target side of a PCI-style host bus. For each address phase it decides whether the access should be claimed at once by positive decode or left for subtractive decode. Positive decode shortens the I/O cycle. The decision depends on a set of fixed legacy I/O port windows and on one memory window for the boot ROM. Each window is switched on by its own enable. Most enables are bits of an 8-bit control register that software reads and writes. The keyboard and real-time-clock enables come in on separate input pins, and the ROM address range is supplied as an input window.

Each decision is registered. It appears one cycle after the address phase as a claim strobe and a two-bit destination code. A claimed IDE access goes to the internal IDE controller. A claimed keyboard, parallel-port or ROM access targets the expansion bus, because no internal device exists for those ports. A claimed real-time-clock access stays inside the core. An access that is not claimed is handed to a small forwarding sequencer. The sequencer first tries the slot bus, and it moves the access to the expansion bus only when that attempt ends in a master abort.

Top module: `lio_claim_top`

## Requirements
- R1: After a synchronous reset the control register reads 20h, `claim` is 0 and the forwarding sequencer is idle, so `slot_req`, `exp_req` and `fwd_done` are all 0.
- R2: While `cfg_we` is high, the control register takes `cfg_wdata` at the clock edge. Bit 6 always reads 0, whatever is written to it.
- R3: The decision for an address phase (`ap_valid` high) is visible on `claim` and `claim_dest` in the next cycle. `claim_dest` is 0 when nothing is claimed, 1 for internal IDE, 2 for the expansion bus and 3 for the internal core block.
- R4: When control bit 3 is set, an I/O access to 1F0h–1F7h, 3F6h or 3F7h is claimed with destination 1. The only exception is an I/O write to 3F7h, which is not claimed.
- R5: When control bit 4 is set, an I/O access to 170h–177h, 376h or 377h is claimed with destination 1. The only exception is an I/O write to 377h, which is not claimed.
- R6: Three parallel-port windows are each claimed with destination 2. Bit 2 enables 278h–27Fh, bit 1 enables 378h–37Fh and bit 0 enables 3BCh–3BFh.
- R7: When `kbd_en` is high, I/O ports 060h and 064h are claimed with destination 2. Ports 062h and 066h are claimed only when `kbd_en` is high and control bit 7 is also set.
- R8: When `rtc_en` is high, I/O ports 070h–073h are claimed with destination 3.
- R9: The I/O windows apply only to command 0010 (I/O read) and command 0011 (I/O write). When control bit 5 is set, a memory command (0110, 0111, 1100, 1110 or 1111) with an address between `rom_lo` and `rom_hi` inclusive is claimed with destination 2. All other accesses are not claimed.
- R10: When an address phase is not claimed and the sequencer is idle, `slot_req` is high for exactly the one cycle in which `claim` is 0. The sequencer then waits. A `slot_ack` ends the sequence, and `fwd_done` is then high for one cycle without any `exp_req`.
- R11: A `slot_mabort` during the wait raises `exp_req` in the next cycle. `exp_req` stays high until `exp_ack`, after which `fwd_done` is high for one cycle.
- R12: A register write in the same cycle as an address phase does not affect that access's decision. The decision uses the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| kbd_en | input | 1 | Keyboard window enable |
| rtc_en | input | 1 | Real-time-clock window enable |
| rom_lo | input | ADDR_W | ROM window lowest address |
| rom_hi | input | ADDR_W | ROM window highest address |
| ap_valid | input | 1 | Address phase present |
| ap_addr | input | ADDR_W | Access address |
| ap_cmd | input | 4 | Bus command code |
| claim | output | 1 | Fast-claim strobe, one cycle after the address phase |
| claim_dest | output | 2 | Destination code of the claimed access |
| slot_req | output | 1 | Forward the unclaimed access to the slot bus |
| slot_ack | input | 1 | Slot bus completed the access |
| slot_mabort | input | 1 | Slot bus attempt ended in master abort |
| exp_req | output | 1 | Forward the access to the expansion bus |
| exp_ack | input | 1 | Expansion bus completed the access |
| fwd_done | output | 1 | Forwarding sequence finished |

## Verification
Two things can fall in the same cycle: a software write to the control register and an address phase whose decode depends on that register. The bench provokes this in a directed case. It arms a window by a write that lands in the address-phase cycle, and the access must stay unclaimed. It also does this in random traffic, where writes are mixed into address-phase cycles at random. It judges each result against a reference model that updates its register copy only after computing the expected decision. A second overlap occurs when a new address phase arrives while the sequencer is busy. In that case the bench checks the decision alone.

// File: rtl/lio_pkg.sv
package lio_pkg;

    typedef enum logic [1:0] {
        DEST_NONE = 2'd0,
        DEST_IDE  = 2'd1,
        DEST_EXP  = 2'd2,
        DEST_CORE = 2'd3
    } dest_e;

    typedef enum logic [2:0] {
        FS_IDLE = 3'd0,
        FS_SLOT = 3'd1,
        FS_WAIT = 3'd2,
        FS_EXP  = 3'd3,
        FS_DONE = 3'd4
    } fwd_state_e;

    localparam logic [3:0] CMD_IO_RD = 4'b0010;
    localparam logic [3:0] CMD_IO_WR = 4'b0011;

    localparam logic [7:0] CTL_RESET = 8'h20;
    localparam logic [7:0] CTL_MASK  = 8'hBF;  // bit 6 reserved
    localparam int         ROM_BIT   = 5;

    // enable sources: 0..7 control bits, then the side inputs
    localparam int EN_W        = 11;
    localparam int SRC_KBD     = 8;
    localparam int SRC_RTC     = 9;
    localparam int SRC_KBD_ALT = 10;

    typedef struct packed {
        logic [11:0] lo;
        logic [11:0] hi;
        logic [3:0]  src;
        dest_e       dest;
        logic        no_wr_hi;  // a write to the top port is not claimed
    } win_t;

    localparam int N_WIN = 12;

    localparam win_t WIN_TAB [N_WIN] = '{
        '{12'h1F0, 12'h1F7, 4'd3,  DEST_IDE,  1'b0},
        '{12'h3F6, 12'h3F7, 4'd3,  DEST_IDE,  1'b1},
        '{12'h170, 12'h177, 4'd4,  DEST_IDE,  1'b0},
        '{12'h376, 12'h377, 4'd4,  DEST_IDE,  1'b1},
        '{12'h3BC, 12'h3BF, 4'd0,  DEST_EXP,  1'b0},
        '{12'h378, 12'h37F, 4'd1,  DEST_EXP,  1'b0},
        '{12'h278, 12'h27F, 4'd2,  DEST_EXP,  1'b0},
        '{12'h060, 12'h060, 4'd8,  DEST_EXP,  1'b0},
        '{12'h064, 12'h064, 4'd8,  DEST_EXP,  1'b0},
        '{12'h062, 12'h062, 4'd10, DEST_EXP,  1'b0},
        '{12'h066, 12'h066, 4'd10, DEST_EXP,  1'b0},
        '{12'h070, 12'h073, 4'd9,  DEST_CORE, 1'b0}
    };

    function automatic logic is_io_cmd(input logic [3:0] c);
        return (c == CMD_IO_RD) || (c == CMD_IO_WR);
    endfunction

    function automatic logic is_mem_cmd(input logic [3:0] c);
        return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
               (c == 4'b1110) || (c == 4'b1111);
    endfunction

endpackage

// File: rtl/lio_ctl_reg.sv
module lio_ctl_reg
    import lio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= CTL_RESET;
        else if (we)
            q <= wdata & CTL_MASK;
    end

endmodule

// File: rtl/lio_win_decode.sv
module lio_win_decode
    import lio_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    input  logic [7:0]        ctl,
    input  logic              kbd_en,
    input  logic              rtc_en,
    input  logic [ADDR_W-1:0] rom_lo,
    input  logic [ADDR_W-1:0] rom_hi,
    output logic              hit,
    output dest_e             dest
);

    logic [EN_W-1:0]  en_src;
    logic [N_WIN-1:0] win_hit;
    logic             io_cmd;
    logic             io_wr;
    logic             rom_hit;

    assign en_src = {kbd_en & ctl[7], rtc_en, kbd_en, ctl};
    assign io_cmd = is_io_cmd(cmd);
    assign io_wr  = (cmd == CMD_IO_WR);

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_TAB[w].lo);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_TAB[w].hi);
        logic in_rng;
        logic wr_excl;
        assign in_rng  = (addr >= LO) && (addr <= HI);
        assign wr_excl = WIN_TAB[w].no_wr_hi && io_wr && (addr == HI);
        assign win_hit[w] = io_cmd && en_src[WIN_TAB[w].src] && in_rng && !wr_excl;
    end

    assign rom_hit = ctl[ROM_BIT] && is_mem_cmd(cmd) &&
                     (addr >= rom_lo) && (addr <= rom_hi);

    always_comb begin
        dest = DEST_NONE;
        for (int w = 0; w < N_WIN; w++) begin
            if (win_hit[w])
                dest = WIN_TAB[w].dest;
        end
        if (rom_hit)
            dest = DEST_EXP;
    end

    assign hit = rom_hit || (|win_hit);

endmodule

// File: rtl/lio_fwd_seq.sv
module lio_fwd_seq
    import lio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic slot_ack,
    input  logic slot_mabort,
    input  logic exp_ack,
    output logic slot_req,
    output logic exp_req,
    output logic done
);

    fwd_state_e st, nxt;

    always_ff @(posedge clk) begin
        if (rst)
            st <= FS_IDLE;
        else
            st <= nxt;
    end

    always_comb begin
        nxt = st;
        case (st)
            FS_IDLE: if (start) nxt = FS_SLOT;
            FS_SLOT: nxt = FS_WAIT;
            FS_WAIT: begin
                if (slot_mabort)
                    nxt = FS_EXP;
                else if (slot_ack)
                    nxt = FS_DONE;
            end
            FS_EXP:  if (exp_ack) nxt = FS_DONE;
            FS_DONE: nxt = FS_IDLE;
            default: nxt = FS_IDLE;
        endcase
    end

    assign slot_req = (st == FS_SLOT);
    assign exp_req  = (st == FS_EXP);
    assign done     = (st == FS_DONE);

endmodule

// File: rtl/lio_claim_top.sv
module lio_claim_top
    import lio_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              kbd_en,
    input  logic              rtc_en,
    input  logic [ADDR_W-1:0] rom_lo,
    input  logic [ADDR_W-1:0] rom_hi,
    input  logic              ap_valid,
    input  logic [ADDR_W-1:0] ap_addr,
    input  logic [3:0]        ap_cmd,
    output logic              claim,
    output logic [1:0]        claim_dest,
    output logic              slot_req,
    input  logic              slot_ack,
    input  logic              slot_mabort,
    output logic              exp_req,
    input  logic              exp_ack,
    output logic              fwd_done
);

    logic [7:0] ctl;
    logic       dec_hit;
    dest_e      dec_dest;
    logic       claim_q;
    dest_e      dest_q;

    lio_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (ctl)
    );

    lio_win_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (ap_addr),
        .cmd    (ap_cmd),
        .ctl    (ctl),
        .kbd_en (kbd_en),
        .rtc_en (rtc_en),
        .rom_lo (rom_lo),
        .rom_hi (rom_hi),
        .hit    (dec_hit),
        .dest   (dec_dest)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            claim_q <= 1'b0;
            dest_q  <= DEST_NONE;
        end else begin
            claim_q <= ap_valid && dec_hit;
            dest_q  <= (ap_valid && dec_hit) ? dec_dest : DEST_NONE;
        end
    end

    lio_fwd_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (ap_valid && !dec_hit),
        .slot_ack    (slot_ack),
        .slot_mabort (slot_mabort),
        .exp_ack     (exp_ack),
        .slot_req    (slot_req),
        .exp_req     (exp_req),
        .done        (fwd_done)
    );

    assign cfg_rdata  = ctl;
    assign claim      = claim_q;
    assign claim_dest = dest_q;

endmodule

// File: rtl/lio_claim_chk.sv
module lio_claim_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic              kbd_en,
    input logic              rtc_en,
    input logic [ADDR_W-1:0] rom_lo,
    input logic [ADDR_W-1:0] rom_hi,
    input logic              ap_valid,
    input logic [ADDR_W-1:0] ap_addr,
    input logic [3:0]        ap_cmd,
    input logic              claim,
    input logic [1:0]        claim_dest,
    input logic              slot_req,
    input logic              slot_ack,
    input logic              slot_mabort,
    input logic              exp_req,
    input logic              exp_ack,
    input logic              fwd_done
);

    assert_rsvd_bit_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[6] == 1'b0);

    assert_claim_after_phase_R3: assert property (@(posedge clk) disable iff (rst)
        claim |-> $past(ap_valid));

    assert_dest_matches_claim_R3: assert property (@(posedge clk) disable iff (rst)
        (claim_dest != 2'd0) == claim);

    assert_slot_only_unclaimed_R10: assert property (@(posedge clk) disable iff (rst)
        slot_req |-> (!claim && $past(ap_valid)));

    assert_slot_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        slot_req |=> !slot_req);

    assert_exp_after_abort_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(exp_req) |-> $past(slot_mabort));

    assert_exp_held_R11: assert property (@(posedge clk) disable iff (rst)
        (exp_req && !exp_ack) |=> exp_req);

    assert_fwd_outputs_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({slot_req, exp_req, fwd_done}));

endmodule

bind lio_claim_top lio_claim_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_lio_claim_top.sv
`timescale 1ns/1ps
module sim_lio_claim_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        kbd_en = 1'b0;
    logic        rtc_en = 1'b0;
    logic [31:0] rom_lo = 32'h000F_0000;
    logic [31:0] rom_hi = 32'h000F_FFFF;
    logic        ap_valid = 1'b0;
    logic [31:0] ap_addr = 32'h0;
    logic [3:0]  ap_cmd = 4'h0;
    logic        claim;
    logic [1:0]  claim_dest;
    logic        slot_req;
    logic        slot_ack = 1'b1;
    logic        slot_mabort = 1'b0;
    logic        exp_req;
    logic        exp_ack = 1'b0;
    logic        fwd_done;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] ctl_m = 8'h20;

    always #2 clk = ~clk;

    lio_claim_top #(.ADDR_W(32)) u0 (.*);

    // bench-side window list: lo, hi, requirement tag
    logic [11:0] b_lo [12] = '{12'h1F0, 12'h3F6, 12'h170, 12'h376, 12'h278, 12'h378,
                               12'h3BC, 12'h060, 12'h064, 12'h062, 12'h066, 12'h070};
    logic [11:0] b_hi [12] = '{12'h1F7, 12'h3F7, 12'h177, 12'h377, 12'h27F, 12'h37F,
                               12'h3BF, 12'h060, 12'h064, 12'h062, 12'h066, 12'h073};
    string       b_tag [12] = '{"R4", "R4", "R5", "R5", "R6", "R6",
                                "R6", "R7", "R7", "R7", "R7", "R8"};

    function automatic logic [2:0] ref_dec(input logic [31:0] a, input logic [3:0] c,
                                           input logic [7:0] k, input logic kb, input logic rt);
        logic io, wr, mem;
        io  = (c == 4'h2) || (c == 4'h3);
        wr  = (c == 4'h3);
        mem = (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
        if (io) begin
            if (kb && (a == 32'h60 || a == 32'h64)) return 3'b110;
            if (kb && k[7] && (a == 32'h62 || a == 32'h66)) return 3'b110;
            if (rt && a >= 32'h70 && a <= 32'h73) return 3'b111;
            if (k[3] && ((a >= 32'h1F0 && a <= 32'h1F7) || a == 32'h3F6 ||
                         (a == 32'h3F7 && !wr))) return 3'b101;
            if (k[4] && ((a >= 32'h170 && a <= 32'h177) || a == 32'h376 ||
                         (a == 32'h377 && !wr))) return 3'b101;
            if (k[2] && a >= 32'h278 && a <= 32'h27F) return 3'b110;
            if (k[1] && a >= 32'h378 && a <= 32'h37F) return 3'b110;
            if (k[0] && a >= 32'h3BC && a <= 32'h3BF) return 3'b110;
        end
        if (mem && k[5] && a >= rom_lo && a <= rom_hi) return 3'b110;
        return 3'b000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        ctl_m = d & 8'hBF;
        chk(cfg_rdata == ctl_m, "R2", {24'h0, cfg_rdata}, {24'h0, ctl_m});
    endtask

    // one address phase, optional same-cycle register write (R12)
    task automatic access(input logic [31:0] a, input logic [3:0] c, input bit w,
                          input logic [7:0] wd, input string tag);
        logic [2:0] e;
        @(negedge clk);
        e = ref_dec(a, c, ctl_m, kbd_en, rtc_en);
        ap_valid = 1'b1;
        ap_addr = a;
        ap_cmd = c;
        cfg_we = w;
        cfg_wdata = wd;
        if (w) ctl_m = wd & 8'hBF;
        @(negedge clk);
        ap_valid = 1'b0;
        cfg_we = 1'b0;
        chk({claim, claim_dest} == e, tag, {29'h0, claim, claim_dest}, {29'h0, e});
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] sweep_ctl [10];
        int seed_v;
        seed_v = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 8'h20, "R1", {24'h0, cfg_rdata}, 32'h20);
        chk({claim, slot_req, exp_req, fwd_done} == 4'b0, "R1",
            {28'h0, claim, slot_req, exp_req, fwd_done}, 32'h0);

        // R2 reserved bit
        do_wr(8'hFF);
        do_wr(8'h40);

        // boundary sweep, both directions, enable combinations
        sweep_ctl = '{8'h00, 8'hBF, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h80, 8'h98};
        for (int s = 0; s < 10; s++) begin
            do_wr(sweep_ctl[s]);
            for (int kr = 0; kr < 4; kr++) begin
                kbd_en = kr[0];
                rtc_en = kr[1];
                for (int wi = 0; wi < 12; wi++) begin
                    for (int d = 0; d < 2; d++) begin
                        logic [3:0] cm;
                        cm = d[0] ? 4'h3 : 4'h2;
                        access({20'h0, b_lo[wi]} - 32'h1, cm, 1'b0, 8'h0, b_tag[wi]);
                        access({20'h0, b_lo[wi]},         cm, 1'b0, 8'h0, b_tag[wi]);
                        access({20'h0, b_hi[wi]},         cm, 1'b0, 8'h0, b_tag[wi]);
                        access({20'h0, b_hi[wi]} + 32'h1, cm, 1'b0, 8'h0, b_tag[wi]);
                    end
                end
                // ROM window edges, memory and I/O commands (R9)
                access(rom_lo - 32'h1, 4'h6, 1'b0, 8'h0, "R9");
                access(rom_lo,         4'h7, 1'b0, 8'h0, "R9");
                access(rom_hi,         4'hC, 1'b0, 8'h0, "R9");
                access(rom_hi + 32'h1, 4'hE, 1'b0, 8'h0, "R9");
                access(rom_lo,         4'h2, 1'b0, 8'h0, "R9");
                access(32'h1F0,        4'h6, 1'b0, 8'h0, "R9");
                access(32'h60,         4'hA, 1'b0, 8'h0, "R9");
            end
        end

        // R12 directed: write arms primary IDE in the address-phase cycle
        do_wr(8'h20);
        settle();
        access(32'h1F0, 4'h2, 1'b1, 8'h08, "R12");
        chk(claim == 1'b0, "R12", {31'h0, claim}, 32'h0);
        settle();
        access(32'h1F0, 4'h2, 1'b0, 8'h0, "R12");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            logic [3:0]  c;
            logic [3:0]  cmds [6] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hF};
            int k;
            kbd_en = $urandom_range(0, 1);
            rtc_en = $urandom_range(0, 1);
            k = $urandom_range(0, 11);
            case ($urandom_range(0, 3))
                0: a = {20'h0, b_lo[k]} + $urandom_range(0, 1) - 32'h1 + $urandom_range(0, 1);
                1: a = {20'h0, b_hi[k]} + $urandom_range(0, 1);
                2: a = rom_lo + $urandom_range(0, 2) - 32'h1 + (($urandom_range(0, 1) == 1) ? 32'h10000 : 32'h0);
                default: a = {20'h0, 12'($urandom_range(0, 4095))};
            endcase
            c = cmds[$urandom_range(0, 5)];
            access(a, c, ($urandom_range(0, 7) == 0), 8'($urandom_range(0, 255)), "R3");
            chk(cfg_rdata == ctl_m, "R2", {24'h0, cfg_rdata}, {24'h0, ctl_m});
        end

        // forwarding sequencer, directed
        do_wr(8'h00);
        settle();
        slot_ack = 1'b0;
        // claimed access does not start forwarding (R10)
        kbd_en = 1'b1;
        access(32'h64, 4'h2, 1'b0, 8'h0, "R7");
        chk(slot_req == 1'b0, "R10", {31'h0, slot_req}, 32'h0);

        // master-abort path (R11)
        access(32'h1F0, 4'h2, 1'b0, 8'h0, "R10");
        chk(slot_req == 1'b1 && exp_req == 1'b0, "R10", {30'h0, slot_req, exp_req}, 32'h2);
        @(negedge clk);
        chk(slot_req == 1'b0 && fwd_done == 1'b0, "R10", {30'h0, slot_req, fwd_done}, 32'h0);
        slot_mabort = 1'b1;
        @(negedge clk);
        slot_mabort = 1'b0;
        chk(exp_req == 1'b1, "R11", {31'h0, exp_req}, 32'h1);
        @(negedge clk);
        chk(exp_req == 1'b1 && fwd_done == 1'b0, "R11", {30'h0, exp_req, fwd_done}, 32'h2);
        exp_ack = 1'b1;
        @(negedge clk);
        exp_ack = 1'b0;
        chk(fwd_done == 1'b1 && exp_req == 1'b0, "R11", {30'h0, fwd_done, exp_req}, 32'h2);
        @(negedge clk);
        chk(fwd_done == 1'b0, "R11", {31'h0, fwd_done}, 32'h0);

        // slot acknowledge path (R10)
        access(32'h3F7, 4'h3, 1'b0, 8'h0, "R4");
        chk(slot_req == 1'b1, "R10", {31'h0, slot_req}, 32'h1);
        repeat (3) @(negedge clk);
        chk(slot_req == 1'b0 && fwd_done == 1'b0 && exp_req == 1'b0, "R10",
            {29'h0, slot_req, fwd_done, exp_req}, 32'h0);
        slot_ack = 1'b1;
        @(negedge clk);
        slot_ack = 1'b0;
        chk(fwd_done == 1'b1 && exp_req == 1'b0, "R10", {30'h0, fwd_done, exp_req}, 32'h2);
        @(negedge clk);
        chk(fwd_done == 1'b0 && exp_req == 1'b0, "R10", {30'h0, fwd_done, exp_req}, 32'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule